// File: doc/BRIEF.md
# Stop-the-Clock Reaction Timer

This block is a complete stop-the-clock game that runs from one 20 MHz clock. After power-up, and again each time the clear button is released, a decimal stopwatch runs from 00.00 up to 99.99 seconds. A player tries to press the stop button at a chosen target time. Once pressed, the stop button freezes the shown time. It keeps the time frozen until the clear button is pressed again.

Both buttons arrive as raw, bouncing inputs. Each button passes through a two-flop synchronizer and then a sampled shift-register filter. The time is held as four BCD digits, which are advanced by a 10 ms prescaler. The digits are shown on a four-position multiplexed seven-segment display. The segment lines and the position enables are both active low.

All interfaces are plain level pins. There is no streaming data path, so no valid/ready handshake applies, and the block never needs to apply back-pressure.

Top module: `reaction_timer`

## Requirements
- R1: A button level is accepted only after the synchronized input has read the same value on DEB_LEN consecutive samples. Samples are taken once every SAMPLE_DIV clock cycles. A pulse shorter than that has no effect on the count.
- R2: The filtered stop level is sticky. Once set, it stays set through any later button activity, until the filtered clear level goes high.
- R3: While the filtered clear level is high, the prescaler, all four digits and the stop level are held at zero. Counting resumes on the first cycle after the clear level falls.
- R4: While the block is running, the hundredths digit advances once every TICK_DIV cycles. While stop is set, the prescaler holds, so the digits do not change.
- R5: Each digit counts 0 to 9 in BCD. When a digit wraps from 9 to 0, the next higher digit advances on the same clock edge. The digits, from lowest to highest, are hundredths, tenths, seconds and tens of seconds.
- R6: From 99.99 the count wraps to 00.00. A run of N ticks therefore shows N mod 10000.
- R7: Exactly one position enable is low at a time. The active position moves every SCAN_DIV cycles in the order enable bit 0, 1, 2, 3 and then back to 0. Bit 0 is the rightmost position and shows hundredths; bit 3 shows tens of seconds.
- R8: The segment lines are bit 0 = a through bit 6 = g, and a segment is lit when its line is 0. The lit sets for the digits 0 to 9 are: 0 = abcdef, 1 = bc, 2 = abdeg, 3 = abcdg, 4 = bcfg, 5 = acdfg, 6 = acdefg, 7 = abc, 8 = all seven segments, 9 = abcdfg. The shown nibble and the position enable change on the same clock edge.
- R9: The decimal point output is low only while position 2 (the seconds digit) is enabled, so the display reads SS.hh.
- R10: While rst_n is low, every counter and filter clears. Position 0 is enabled, showing the digit 0 with the decimal point off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz system clock |
| rst_n | input | 1 | Synchronous power-on reset, active low |
| stop_btn_i | input | 1 | Raw stop push button, active high |
| clear_btn_i | input | 1 | Raw clear/restart push button, active high |
| seg_n_o | output | 7 | Segment lines a..g (bit 0 = a), active low |
| dp_n_o | output | 1 | Decimal point line, active low |
| dig_en_n_o | output | 4 | Position enables, bit 0 rightmost, active low |

## Verification
The hardest state to reach from the ports is a frozen count whose exact tick total is known. Each button filter adds a latency that depends on the sampling phase. The stimulus gets around this by releasing clear and pressing stop on edges that are exactly N·TICK_DIV cycles apart, where TICK_DIV is a multiple of SAMPLE_DIV. Both filters then see the same phase, so the running window is exactly N ticks long, and the frozen display must read N mod 10000. Long runs (9999 and 10001 ticks) reach the 99.99 limit and the wrap past it with shrunken divider parameters. A sub-threshold stop glitch inside a measured run shows that rejected bounce leaves the count untouched.

// File: rtl/reaction_timer_pkg.sv
package reaction_timer_pkg;

  localparam int NUM_DIGITS = 4;
  localparam int DP_POSITION = 2;

  typedef logic [3:0] bcd_t;

  // active-high segment set, bit0 = a ... bit6 = g
  function automatic logic [6:0] hex_to_lit(input bcd_t v);
    logic [6:0] s;
    case (v)
      4'h0: s = 7'h3F;
      4'h1: s = 7'h06;
      4'h2: s = 7'h5B;
      4'h3: s = 7'h4F;
      4'h4: s = 7'h66;
      4'h5: s = 7'h6D;
      4'h6: s = 7'h7D;
      4'h7: s = 7'h07;
      4'h8: s = 7'h7F;
      4'h9: s = 7'h6F;
      4'hA: s = 7'h77;
      4'hB: s = 7'h7C;
      4'hC: s = 7'h39;
      4'hD: s = 7'h5E;
      4'hE: s = 7'h79;
      default: s = 7'h71;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/rt_pulse_div.sv
// Free or held modulo-DIV counter; one-cycle strobe on its last state.
module rt_pulse_div #(
  parameter int DIV = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic hold_i,
  output logic pulse_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (!hold_i) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign pulse_o = !clr_i && !hold_i && (cnt_q == LAST);
endmodule

// File: rtl/rt_btn_filter.sv
// Synchronizer plus sampled shift-register filter.
// STICKY=1: set on a full run of ones, cleared only by clr_i.
// STICKY=0: follows full runs of ones / zeros, holds otherwise.
module rt_btn_filter #(
  parameter int DEB_LEN = 8,
  parameter bit STICKY  = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_en_i,
  input  logic clr_i,
  input  logic btn_i,
  output logic level_o
);
  logic [1:0]         sync_q;
  logic [DEB_LEN-1:0] shr_q;
  logic               lvl_q;
  logic               all_one;
  logic               all_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      shr_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], btn_i};
      if (smp_en_i) shr_q <= {shr_q[DEB_LEN-2:0], sync_q[1]};
    end
  end

  assign all_one  = &shr_q;
  assign all_zero = ~|shr_q;

  generate
    if (STICKY) begin : g_latch
      always_ff @(posedge clk) begin
        if (!rst_n)                    lvl_q <= 1'b0;
        else if (clr_i)                lvl_q <= 1'b0;
        else if (smp_en_i && all_one)  lvl_q <= 1'b1;
      end
    end else begin : g_follow
      always_ff @(posedge clk) begin
        if (!rst_n)                    lvl_q <= 1'b0;
        else if (clr_i)                lvl_q <= 1'b0;
        else if (smp_en_i && all_one)  lvl_q <= 1'b1;
        else if (smp_en_i && all_zero) lvl_q <= 1'b0;
      end
    end
  endgenerate

  assign level_o = lvl_q;
endmodule

// File: rtl/rt_bcd_chain.sv
// 10 ms prescaler feeding a cascade of BCD digits (same-edge carry).
module rt_bcd_chain
  import reaction_timer_pkg::*;
#(
  parameter int TICK_DIV = 200000,
  parameter int NDIG     = NUM_DIGITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_i,
  input  logic                 hold_i,
  output logic [NDIG-1:0][3:0] dig_o
);
  logic                 tick;
  logic [NDIG-1:0]      carry;
  logic [NDIG-1:0][3:0] dig_q;

  rt_pulse_div #(.DIV(TICK_DIV)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr_i),
    .hold_i (hold_i),
    .pulse_o(tick)
  );

  assign carry[0] = tick;

  generate
    for (genvar i = 0; i < NDIG; i++) begin : g_dig
      always_ff @(posedge clk) begin
        if (!rst_n)         dig_q[i] <= '0;
        else if (clr_i)     dig_q[i] <= '0;
        else if (carry[i])  dig_q[i] <= (dig_q[i] == 4'd9) ? 4'd0 : dig_q[i] + 4'd1;
      end
      if (i < NDIG - 1) begin : g_carry
        assign carry[i+1] = carry[i] && (dig_q[i] == 4'd9);
      end
    end
  endgenerate

  assign dig_o = dig_q;
endmodule

// File: rtl/rt_scan_mux.sv
// Rotating position select; nibble, enable and point all load on one edge.
module rt_scan_mux
  import reaction_timer_pkg::*;
#(
  parameter int SCAN_DIV = 100000,
  parameter int NDIG     = NUM_DIGITS,
  parameter int DP_POS   = DP_POSITION
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NDIG-1:0][3:0] dig_i,
  output logic [6:0]           seg_n_o,
  output logic                 dp_n_o,
  output logic [NDIG-1:0]      en_n_o
);
  localparam int PW = (NDIG > 1) ? $clog2(NDIG) : 1;
  localparam logic [PW-1:0] POS_LAST = PW'(NDIG - 1);
  localparam logic [PW-1:0] POS_DP   = PW'(DP_POS);

  logic            adv;
  logic [PW-1:0]   pos_q;
  logic [PW-1:0]   pos_nxt;
  logic [NDIG-1:0] sel_q;
  bcd_t            nib_q;
  logic            dp_q;

  rt_pulse_div #(.DIV(SCAN_DIV)) u_scan (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (1'b0),
    .hold_i (1'b0),
    .pulse_o(adv)
  );

  always_comb begin
    pos_nxt = pos_q;
    if (adv) pos_nxt = (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= '0;
      sel_q <= NDIG'(1);
      nib_q <= '0;
      dp_q  <= 1'b0;
    end else begin
      pos_q <= pos_nxt;
      sel_q <= NDIG'(1) << pos_nxt;
      nib_q <= dig_i[pos_nxt];
      dp_q  <= (pos_nxt == POS_DP);
    end
  end

  assign seg_n_o = ~hex_to_lit(nib_q);
  assign dp_n_o  = ~dp_q;
  assign en_n_o  = ~sel_q;
endmodule

// File: rtl/reaction_timer.sv
module reaction_timer
  import reaction_timer_pkg::*;
#(
  parameter int SAMPLE_DIV = 20000,
  parameter int DEB_LEN    = 8,
  parameter int TICK_DIV   = 200000,
  parameter int SCAN_DIV   = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_btn_i,
  input  logic       clear_btn_i,
  output logic [6:0] seg_n_o,
  output logic       dp_n_o,
  output logic [3:0] dig_en_n_o
);
  logic                       smp_en;
  logic                       stop_lvl;
  logic                       clr_lvl;
  logic [NUM_DIGITS-1:0][3:0] digits;

  rt_pulse_div #(.DIV(SAMPLE_DIV)) u_smp (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (1'b0),
    .hold_i (1'b0),
    .pulse_o(smp_en)
  );

  rt_btn_filter #(.DEB_LEN(DEB_LEN), .STICKY(1'b0)) u_clr_flt (
    .clk     (clk),
    .rst_n   (rst_n),
    .smp_en_i(smp_en),
    .clr_i   (1'b0),
    .btn_i   (clear_btn_i),
    .level_o (clr_lvl)
  );

  rt_btn_filter #(.DEB_LEN(DEB_LEN), .STICKY(1'b1)) u_stop_flt (
    .clk     (clk),
    .rst_n   (rst_n),
    .smp_en_i(smp_en),
    .clr_i   (clr_lvl),
    .btn_i   (stop_btn_i),
    .level_o (stop_lvl)
  );

  rt_bcd_chain #(.TICK_DIV(TICK_DIV), .NDIG(NUM_DIGITS)) u_chain (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (clr_lvl),
    .hold_i(stop_lvl),
    .dig_o (digits)
  );

  rt_scan_mux #(.SCAN_DIV(SCAN_DIV), .NDIG(NUM_DIGITS), .DP_POS(DP_POSITION)) u_mux (
    .clk    (clk),
    .rst_n  (rst_n),
    .dig_i  (digits),
    .seg_n_o(seg_n_o),
    .dp_n_o (dp_n_o),
    .en_n_o (dig_en_n_o)
  );
endmodule

// File: rtl/reaction_timer_chk.sv
module reaction_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        stop_lvl,
  input logic        clr_lvl,
  input logic [15:0] digs,
  input logic [3:0]  dig_en_n,
  input logic        dp_n
);
  // R2: stop stays latched until clear
  a_r2_stop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_lvl && !clr_lvl) |=> stop_lvl);

  // R3: clear forces the count to zero
  a_r3_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr_lvl |=> (digs == 16'h0000));

  // R3: clear also drops a latched stop
  a_r3_clear_drops_stop: assert property (@(posedge clk) disable iff (!rst_n)
    clr_lvl |=> !stop_lvl);

  // R4: a stopped count does not move
  a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_lvl && !clr_lvl) |=> $stable(digs));

  // R5: every digit stays decimal
  a_r5_bcd_range: assert property (@(posedge clk) disable iff (!rst_n)
    (digs[3:0] <= 4'd9) && (digs[7:4] <= 4'd9) &&
    (digs[11:8] <= 4'd9) && (digs[15:12] <= 4'd9));

  // R7: one position enabled at a time
  a_r7_one_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~dig_en_n) == 1);

  // R9: point only with the seconds position
  a_r9_dp_seconds: assert property (@(posedge clk) disable iff (!rst_n)
    (!dp_n) == (dig_en_n == 4'b1011));
endmodule

bind reaction_timer reaction_timer_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .stop_lvl(stop_lvl),
  .clr_lvl (clr_lvl),
  .digs    (digits),
  .dig_en_n(dig_en_n_o),
  .dp_n    (dp_n_o)
);

// File: tb/reaction_timer_tb.sv
`timescale 1ns/1ps
module reaction_timer_tb;
  localparam int SAMPLE_DIV = 2;
  localparam int DEB_LEN    = 4;
  localparam int TICK_DIV   = 2;
  localparam int SCAN_DIV   = 5;
  localparam int NCASE      = 8;

  localparam int unsigned RUN_TICKS [NCASE] =
    '{3, 10, 99, 100, 1234, 5678, 9999, 10001};
  localparam logic [15:0] RUN_SHOW [NCASE] =
    '{16'h0003, 16'h0010, 16'h0099, 16'h0100, 16'h1234, 16'h5678, 16'h9999, 16'h0001};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stop_btn = 1'b0;
  logic       clear_btn = 1'b0;
  logic [6:0] seg_n;
  logic       dp_n;
  logic [3:0] en_n;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  reaction_timer #(
    .SAMPLE_DIV(SAMPLE_DIV), .DEB_LEN(DEB_LEN),
    .TICK_DIV(TICK_DIV), .SCAN_DIV(SCAN_DIV)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .stop_btn_i(stop_btn), .clear_btn_i(clear_btn),
    .seg_n_o(seg_n), .dp_n_o(dp_n), .dig_en_n_o(en_n)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual cycles=%0d expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic logic [6:0] lit_of(input int d);
    case (d)
      0: return 7'b0111111;
      1: return 7'b0000110;
      2: return 7'b1011011;
      3: return 7'b1001111;
      4: return 7'b1100110;
      5: return 7'b1101101;
      6: return 7'b1111101;
      7: return 7'b0000111;
      8: return 7'b1111111;
      default: return 7'b1101111;
    endcase
  endfunction

  function automatic logic [3:0] decode(input logic [6:0] s_n);
    for (int d = 0; d < 10; d++) if (~s_n == lit_of(d)) return 4'(d);
    return 4'hF;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_pos(input int p, output logic [3:0] v, output logic dp);
    @(negedge clk);
    while (en_n != ~(4'b0001 << p)) @(negedge clk);
    v  = decode(seg_n);
    dp = dp_n;
  endtask

  task automatic read_all(output logic [15:0] val);
    logic [3:0] v;
    logic       dp;
    for (int p = 0; p < 4; p++) begin
      read_pos(p, v, dp);
      val[p*4 +: 4] = v;
    end
  endtask

  task automatic clear_pulse();
    clear_btn = 1'b1;
    cycles(60);
  endtask

  // release clear, run exactly n ticks, then press stop (phases aligned)
  task automatic timed_run(input int unsigned n, input bit glitch);
    clear_btn = 1'b0;
    if (glitch) begin
      cycles(20);
      stop_btn = 1'b1;
      cycles(3);
      stop_btn = 1'b0;
      cycles(int'(n) * TICK_DIV - 23);
    end else begin
      cycles(int'(n) * TICK_DIV);
    end
    stop_btn = 1'b1;
    cycles(40);
    stop_btn = 1'b0;
    cycles(20);
  endtask

  initial begin
    logic [15:0] got;
    logic [15:0] got2;
    logic [3:0]  v;
    logic        dp;

    // R10: reset state
    cycles(5);
    check(en_n == 4'b1110, "R10 enable", en_n, 4'b1110);
    check(seg_n == ~lit_of(0), "R10 segments", seg_n, ~lit_of(0));
    check(dp_n == 1'b1, "R10 point", dp_n, 1);
    rst_n = 1'b1;

    // R7: rotation order and period
    begin
      logic [3:0] prev;
      int         gap;
      @(negedge clk);
      prev = en_n;
      while (en_n == prev) @(negedge clk);
      for (int k = 0; k < 4; k++) begin
        prev = en_n;
        gap = 0;
        while (en_n == prev) begin
          @(negedge clk);
          gap++;
        end
        check(en_n == {prev[2:0], prev[3]}, "R7 order", en_n, {prev[2:0], prev[3]});
        check(gap == SCAN_DIV, "R7 period", gap, SCAN_DIV);
      end
    end

    // R9: point position
    for (int p = 0; p < 4; p++) begin
      read_pos(p, v, dp);
      check(dp == (p != 2), "R9 point", dp, (p != 2));
    end

    // R4 R5 R6 R8: table of timed runs, exact tick counts
    for (int i = 0; i < NCASE; i++) begin
      clear_pulse();
      timed_run(RUN_TICKS[i], 1'b0);
      read_all(got);
      check(got == RUN_SHOW[i], "R4/R5/R6/R8 timed run", got, RUN_SHOW[i]);
    end

    // R2: stop stays latched after button release
    cycles(300);
    read_all(got2);
    check(got2 == 16'h0001, "R2 sticky stop", got2, 16'h0001);
    stop_btn = 1'b1;
    cycles(30);
    stop_btn = 1'b0;
    cycles(30);
    read_all(got2);
    check(got2 == 16'h0001, "R2 repress no effect", got2, 16'h0001);

    // R3: held clear keeps zero
    clear_btn = 1'b1;
    cycles(400);
    read_all(got);
    check(got == 16'h0000, "R3 clear held zero", got, 0);

    // R1: glitch on stop shorter than the filter is ignored
    timed_run(50, 1'b1);
    read_all(got);
    check(got == 16'h0050, "R1 glitch ignored", got, 16'h0050);

    // R3: count restarts after release (short run)
    clear_pulse();
    timed_run(7, 1'b0);
    read_all(got);
    check(got == 16'h0007, "R3 restart", got, 16'h0007);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule